// File: doc/BRIEF.md
# Buzzer Tone Generator with Duty Envelope

This block makes a square-wave buzzer tone from a 32 kHz reference clock, which is also its own clock. One of eight tone periods is taken from a fixed divisor table. One of eight high-time fractions sets how loud the tone sounds: the loudness comes from the duty ratio, not from the amplitude. An optional envelope starts at the loudest duty and moves one level quieter at a fixed step period, which gives a decaying tone. A one-shot timer, run from a 256 Hz tick made by dividing the reference by 128, plays a short burst for key-click feedback.

A tone plays while the continuous run input is high or while a one-shot burst is in progress. When the output enable is low, the pin carries the general-purpose port data and direction instead of the tone. The enable is not aligned to the waveform, so switching it can cut a tone cycle short. When the clock enable is low, the tone counter, the 256 Hz prescaler, the envelope stepping and the burst timer all stop, and no tone is made.

Top module: `buzz_tone_gen`

## Requirements
- R1: The tone period, in clock cycles, follows freq_sel: codes 0 to 7 give 8, 10, 12, 14, 16, 20, 24 and 32 cycles. There is exactly one rising edge per period.
- R2: The high time per period is floor(P*(16-L)/32) cycles, where P is the period and L is the effective level (0 to 7). L = 0 gives half duty, and larger L gives less high time.
- R3: When env_en is high, the effective level replaces level_sel. It starts at 0 and rises by one after every 16 ticks of 256 Hz (env_slow=0) or every 32 ticks (env_slow=1), where one tick is 128 clock cycles. It stays at 7 once it gets there. When env_en is low, the envelope is held at level 0.
- R4: A pulse on env_restart returns the envelope to level 0 and restarts its step count.
- R5: A pulse on shot_trig starts a burst. The burst lasts 8 ticks (shot_long=0) or 32 ticks (shot_long=1) and then stops by itself.
- R6: A trigger during a burst restarts the tick count, so the burst lasts a full width from the latest trigger.
- R7: A pulse on shot_stop ends a burst; the tone is low from the second clock edge onward. Stop takes priority over a trigger in the same cycle.
- R8: With tone_run low and no burst in progress, the tone output is low. With tone_run high, the tone plays without a break.
- R9: While clk_en is low, the tone is low, and triggers have no effect, including after clk_en returns high.
- R10: With out_en high, pin_out carries the tone and pin_oe is 1. With out_en low, pin_out equals gpio_out and pin_oe equals gpio_dir, whatever the tone is doing.
- R11: After reset the tone is low, no burst is in progress and the envelope is at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Enables all counting in the generator |
| tone_run | input | 1 | Continuous tone request |
| freq_sel | input | 3 | Tone period select |
| level_sel | input | 3 | Duty level select, used while the envelope is off |
| env_en | input | 1 | Envelope enable |
| env_slow | input | 1 | Envelope step period: 0 = 16 ticks, 1 = 32 ticks |
| env_restart | input | 1 | Returns the envelope to the loudest level |
| shot_trig | input | 1 | Starts or restarts a burst |
| shot_long | input | 1 | Burst width: 0 = 8 ticks, 1 = 32 ticks |
| shot_stop | input | 1 | Ends a burst early |
| out_en | input | 1 | Routes the tone to the pin |
| gpio_dir | input | 1 | Port direction used when out_en is low |
| gpio_out | input | 1 | Port data used when out_en is low |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin output enable |

## Verification
If the phase counter holds a wrong value, the high-cycle count or the rising-edge count over a whole number of periods changes within one tone period. If the envelope level or the step count is wrong, the duty read in a window placed between two expected steps is off, and this shows up within about 2048 cycles of the error. If the burst timer is wrong, the tone either keeps playing past the latest possible end of a burst or is already silent before the earliest possible end. Both windows are placed so that the unknown phase of the 256 Hz prescaler cannot affect the result.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    localparam int SEL_W         = 3;
    localparam int LVL_MAX       = 7;
    localparam int PHASE_W       = 6;
    localparam int DEF_PRESCALE  = 128;
    localparam int DEF_ENV_FAST  = 16;
    localparam int DEF_ENV_SLOW  = 32;
    localparam int DEF_SHOT_SHORT = 8;
    localparam int DEF_SHOT_LONG  = 32;

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef struct packed {
        sel_t fsel;
        sel_t lvl;
    } tone_cfg_t;

    // tone period in reference clock cycles
    function automatic phase_t period_of(sel_t s);
        phase_t p;
        case (s)
            3'd0:    p = 6'd8;
            3'd1:    p = 6'd10;
            3'd2:    p = 6'd12;
            3'd3:    p = 6'd14;
            3'd4:    p = 6'd16;
            3'd5:    p = 6'd20;
            3'd6:    p = 6'd24;
            default: p = 6'd32;
        endcase
        return p;
    endfunction

    // high cycles per period: P*(16-L)/32, floored
    function automatic phase_t high_of(phase_t p, sel_t lvl);
        int v;
        v = (int'(p) * (16 - int'(lvl))) >>> 5;
        return PHASE_W'(v);
    endfunction

endpackage

// File: rtl/buzz_prescaler.sv
module buzz_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/buzz_tone.sv
module buzz_tone
    import buzz_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  tone_cfg_t cfg,
    output logic      buzz
);
    phase_t per;
    phase_t hi;
    phase_t cnt;

    assign per = period_of(cfg.fsel);
    assign hi  = high_of(per, cfg.lvl);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt  <= '0;
            buzz <= 1'b0;
        end else begin
            buzz <= (cnt < hi);
            cnt  <= (cnt >= per - 1'b1) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/buzz_envelope.sv
module buzz_envelope
    import buzz_pkg::*;
#(
    parameter int FAST_TICKS = 16,
    parameter int SLOW_TICKS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic slow,
    input  logic restart,
    input  logic tick,
    output sel_t lvl
);
    localparam int MAXT = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int SC_W = (MAXT > 1) ? $clog2(MAXT) : 1;

    logic [SC_W-1:0] sc;
    logic [SC_W-1:0] last;

    assign last = slow ? SC_W'(SLOW_TICKS - 1) : SC_W'(FAST_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst || !en || restart) begin
            sc  <= '0;
            lvl <= '0;
        end else if (tick) begin
            if (sc >= last) begin
                sc <= '0;
                if (lvl != sel_t'(LVL_MAX)) begin
                    lvl <= lvl + 1'b1;
                end
            end else begin
                sc <= sc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/buzz_oneshot.sv
module buzz_oneshot #(
    parameter int SHORT_TICKS = 8,
    parameter int LONG_TICKS  = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic trig,
    input  logic long_sel,
    input  logic stop,
    input  logic tick,
    output logic busy
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int SC_W = (MAXT > 1) ? $clog2(MAXT) : 1;

    logic [SC_W-1:0] sc;
    logic [SC_W-1:0] last;

    assign last = long_sel ? SC_W'(LONG_TICKS - 1) : SC_W'(SHORT_TICKS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            sc   <= '0;
        end else if (run) begin
            if (stop) begin
                busy <= 1'b0;
                sc   <= '0;
            end else if (trig) begin
                busy <= 1'b1;
                sc   <= '0;
            end else if (busy && tick) begin
                if (sc >= last) begin
                    busy <= 1'b0;
                    sc   <= '0;
                end else begin
                    sc <= sc + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
    import buzz_pkg::*;
#(
    parameter int PRESCALE    = DEF_PRESCALE,
    parameter int ENV_FAST    = DEF_ENV_FAST,
    parameter int ENV_SLOW    = DEF_ENV_SLOW,
    parameter int SHOT_SHORT  = DEF_SHOT_SHORT,
    parameter int SHOT_LONG   = DEF_SHOT_LONG
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       tone_run,
    input  logic [2:0] freq_sel,
    input  logic [2:0] level_sel,
    input  logic       env_en,
    input  logic       env_slow,
    input  logic       env_restart,
    input  logic       shot_trig,
    input  logic       shot_long,
    input  logic       shot_stop,
    input  logic       out_en,
    input  logic       gpio_dir,
    input  logic       gpio_out,
    output logic       pin_out,
    output logic       pin_oe
);
    logic      slow_tick;
    logic      shot_busy;
    logic      active;
    logic      buzz;
    sel_t      env_lvl;
    tone_cfg_t cfg;

    buzz_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (clk_en),
        .tick (slow_tick)
    );

    buzz_envelope #(.FAST_TICKS(ENV_FAST), .SLOW_TICKS(ENV_SLOW)) u_env (
        .clk     (clk),
        .rst     (rst),
        .en      (env_en),
        .slow    (env_slow),
        .restart (env_restart),
        .tick    (slow_tick),
        .lvl     (env_lvl)
    );

    buzz_oneshot #(.SHORT_TICKS(SHOT_SHORT), .LONG_TICKS(SHOT_LONG)) u_shot (
        .clk      (clk),
        .rst      (rst),
        .run      (clk_en),
        .trig     (shot_trig),
        .long_sel (shot_long),
        .stop     (shot_stop),
        .tick     (slow_tick),
        .busy     (shot_busy)
    );

    assign active   = clk_en && (tone_run || shot_busy);
    assign cfg.fsel = freq_sel;
    assign cfg.lvl  = env_en ? env_lvl : level_sel;

    buzz_tone u_tone (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .cfg    (cfg),
        .buzz   (buzz)
    );

    // pin mux: not aligned to the waveform, may cut a cycle
    assign pin_out = out_en ? buzz : gpio_out;
    assign pin_oe  = out_en ? 1'b1 : gpio_dir;
endmodule

// File: rtl/buzz_checker.sv
module buzz_checker (
    input logic       clk,
    input logic       rst,
    input logic       clk_en,
    input logic       tone_run,
    input logic       env_en,
    input logic       env_restart,
    input logic       shot_stop,
    input logic       buzz,
    input logic       shot_busy,
    input logic [2:0] env_lvl
);
    a_r9_gate_low: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> !buzz);

    a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
        (!tone_run && !shot_busy) |=> !buzz);

    a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
        env_restart |=> (env_lvl == 3'd0));

    a_r3_env_off_zero: assert property (@(posedge clk) disable iff (rst)
        !env_en |=> (env_lvl == 3'd0));

    a_r3_env_single_step: assert property (@(posedge clk) disable iff (rst)
        (env_en && !env_restart) |=>
            (env_lvl == $past(env_lvl)) ||
            ({1'b0, env_lvl} == {1'b0, $past(env_lvl)} + 4'd1));

    a_r7_stop_clears: assert property (@(posedge clk) disable iff (rst)
        (clk_en && shot_stop) |=> !shot_busy);
endmodule

bind buzz_tone_gen buzz_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .clk_en      (clk_en),
    .tone_run    (tone_run),
    .env_en      (env_en),
    .env_restart (env_restart),
    .shot_stop   (shot_stop),
    .buzz        (buzz),
    .shot_busy   (shot_busy),
    .env_lvl     (env_lvl)
);

// File: tb/tb_buzz_tone_gen.sv
`timescale 1ns/1ps
module tb_buzz_tone_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0, tone_run = 1'b0;
    logic [2:0] freq_sel = '0, level_sel = '0;
    logic       env_en = 1'b0, env_slow = 1'b0, env_restart = 1'b0;
    logic       shot_trig = 1'b0, shot_long = 1'b0, shot_stop = 1'b0;
    logic       out_en = 1'b1, gpio_dir = 1'b0, gpio_out = 1'b0;
    logic       pin_out, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    buzz_tone_gen dut (
        .clk(clk), .rst(rst), .clk_en(clk_en), .tone_run(tone_run),
        .freq_sel(freq_sel), .level_sel(level_sel),
        .env_en(env_en), .env_slow(env_slow), .env_restart(env_restart),
        .shot_trig(shot_trig), .shot_long(shot_long), .shot_stop(shot_stop),
        .out_en(out_en), .gpio_dir(gpio_dir), .gpio_out(gpio_out),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // {freq_sel, level_sel, period, high cycles per period}
    localparam int VEC[8][4] = '{
        '{0, 0,  8,  4}, '{7, 0, 32, 16}, '{3, 2, 14,  6}, '{5, 5, 20,  6},
        '{1, 7, 10,  2}, '{6, 3, 24,  9}, '{4, 6, 16,  5}, '{2, 4, 12,  4}
    };

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input int n, output int hi, output int ri);
        logic prev;
        prev = pin_out;
        hi = 0;
        ri = 0;
        repeat (n) begin
            @(negedge clk);
            if (pin_out) hi++;
            if (pin_out && !prev) ri++;
            prev = pin_out;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig();
        shot_trig = 1'b1; @(negedge clk); shot_trig = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int hi, ri;
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 pin_out after reset", int'(pin_out), 0);
        check("R11 pin_oe after reset", int'(pin_oe), 1);

        clk_en = 1'b1;
        tone_run = 1'b1;
        // R1 / R2 table walk
        for (int i = 0; i < 8; i++) begin
            freq_sel  = 3'(VEC[i][0]);
            level_sel = 3'(VEC[i][1]);
            wait_cyc(70);
            measure(4 * VEC[i][2], hi, ri);
            check($sformatf("R1 rises fsel=%0d", VEC[i][0]), ri, 4);
            check($sformatf("R2 highs fsel=%0d lvl=%0d", VEC[i][0], VEC[i][1]), hi, 4 * VEC[i][3]);
        end

        // R10 port mode: tone must not reach the pin
        out_en = 1'b0; gpio_dir = 1'b0; gpio_out = 1'b1;
        measure(64, hi, ri);
        check("R10 pin_out follows gpio_out", hi, 64);
        check("R10 pin_oe follows gpio_dir", int'(pin_oe), 0);
        gpio_dir = 1'b1; gpio_out = 1'b0;
        measure(64, hi, ri);
        check("R10 pin_out low gpio", hi, 0);
        check("R10 pin_oe high gpio", int'(pin_oe), 1);
        out_en = 1'b1;

        // R9 clock enable off
        clk_en = 1'b0;
        wait_cyc(3);
        measure(64, hi, ri);
        check("R9 tone off while clk_en low", hi, 0);

        // R8 idle
        clk_en = 1'b1;
        tone_run = 1'b0;
        freq_sel = 3'd0; level_sel = 3'd0;
        wait_cyc(3);
        measure(64, hi, ri);
        check("R8 idle low", hi, 0);

        // R9 trigger ignored while disabled
        clk_en = 1'b0;
        pulse_trig();
        wait_cyc(10);
        clk_en = 1'b1;
        wait_cyc(20);
        measure(64, hi, ri);
        check("R9 trigger ignored", hi, 0);

        // R5 short burst
        shot_long = 1'b0;
        pulse_trig();
        wait_cyc(855);
        measure(16, hi, ri);
        check("R5 short burst alive", int'(hi > 0), 1);
        wait_cyc(1044 - 872);
        measure(64, hi, ri);
        check("R5 short burst ended", hi, 0);

        // R5 long burst
        shot_long = 1'b1;
        pulse_trig();
        wait_cyc(3927);
        measure(16, hi, ri);
        check("R5 long burst alive", int'(hi > 0), 1);
        wait_cyc(4116 - 3944);
        measure(64, hi, ri);
        check("R5 long burst ended", hi, 0);

        // R6 retrigger
        shot_long = 1'b0;
        pulse_trig();
        wait_cyc(639);
        pulse_trig();
        wait_cyc(855);
        measure(16, hi, ri);
        check("R6 retrigger extends burst", int'(hi > 0), 1);
        wait_cyc(1044 - 872);
        measure(64, hi, ri);
        check("R6 retriggered burst ended", hi, 0);

        // R7 early stop, and stop beats trigger
        shot_long = 1'b1;
        pulse_trig();
        wait_cyc(300);
        shot_stop = 1'b1; @(negedge clk); shot_stop = 1'b0;
        wait_cyc(1);
        measure(64, hi, ri);
        check("R7 stop ends burst", hi, 0);
        shot_stop = 1'b1; shot_trig = 1'b1; @(negedge clk);
        shot_stop = 1'b0; shot_trig = 1'b0;
        wait_cyc(1);
        measure(64, hi, ri);
        check("R7 stop beats trigger", hi, 0);

        // R3 envelope, fast steps, P=32
        freq_sel = 3'd7; level_sel = 3'd5;
        tone_run = 1'b1;
        env_slow = 1'b0;
        env_en = 1'b1;
        wait_cyc(10);
        measure(128, hi, ri);
        check("R3 envelope starts loud", hi, 64);
        wait_cyc(2300 - 138);
        measure(128, hi, ri);
        check("R3 envelope first step", hi, 60);
        wait_cyc(17000);
        measure(128, hi, ri);
        check("R3 envelope holds at 7", hi, 36);

        // R4 restart
        env_restart = 1'b1; @(negedge clk); env_restart = 1'b0;
        wait_cyc(10);
        measure(128, hi, ri);
        check("R4 restart back to loud", hi, 64);

        // R3 slow steps
        env_slow = 1'b1;
        env_restart = 1'b1; @(negedge clk); env_restart = 1'b0;
        wait_cyc(2300);
        measure(128, hi, ri);
        check("R3 slow not yet stepped", hi, 64);
        wait_cyc(4200 - 2428);
        measure(128, hi, ri);
        check("R3 slow first step", hi, 60);

        // R3 envelope off uses level_sel again (lvl 5, P=32 -> 11)
        env_en = 1'b0;
        wait_cyc(70);
        measure(128, hi, ri);
        check("R3 env off uses level_sel", hi, 44);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule